// File: doc/BRIEF.md
# Microtag Way-Select Read Cache

This block is a four-way set-associative read cache holding 16 KB in 32-byte lines. A read presents a 32-bit byte address. The cache reads all four ways of the addressed set at once. It picks the way whose data word reaches the output by comparing a short 8-bit partial tag, the microtag. At the same time it compares the full 20-bit tag, and only that comparison decides whether the access hits. A partial compare is much shallower than a full one, so the data path no longer waits on the wide tag comparator.

The microtag of a line is the low 8 bits of its full tag. The microtags are kept in an array separate from the full tags. Way selection by microtag is only sound if no two valid lines in one set share a microtag. The fill logic therefore enforces this:
- A fill whose microtag is already present in the set overwrites that line.
- Otherwise the fill takes an invalid way.
- If no way is invalid, a per-set round-robin pointer chooses the victim.

The surrounding system acts as the next memory level. It watches the miss flag and returns whole lines through the fill port.

Top module: `utc_cache`

## Requirements
- R1: After reset every line is invalid, so every read misses. Before the first read, rsp_valid, rsp_hit, rsp_miss and rsp_data are all zero.
- R2: A read presented with rd_valid high is answered exactly one clock later with rsp_valid high. In a cycle after rd_valid was low, rsp_valid, rsp_hit, rsp_miss and rsp_data are all zero.
- R3: The read address is split as follows: bits [4:2] pick the word, bits [11:5] pick the set, bits [31:12] are the tag, and bits [1:0] are ignored. Word k of a line is fill_data[32k+31:32k].
- R4: rsp_hit is high only when a valid way of the set holds the full request tag. rsp_miss equals rsp_valid and not rsp_hit.
- R5: The microtag is tag bits [7:0], which are address bits [19:12]. rsp_data comes from the valid way whose microtag matches the request. If the microtag matches but the full tag differs, the response is a miss and rsp_data carries that way's word.
- R6: When no valid way of the set matches the request microtag, rsp_data is zero.
- R7: A fill whose microtag equals that of a valid way in the target set replaces that way. The old line stops hitting, and no set ever holds two valid lines with one microtag.
- R8: A fill with no microtag match in its set takes the lowest-numbered invalid way.
- R9: A fill into a full set with no microtag match evicts the way named by that set's round-robin pointer. The pointer starts at way 0 after reset and advances by one, wrapping, after each such fill.
- R10: When a read and a fill occur in the same cycle, the read sees the contents from before the fill. The fill is visible to a read one cycle later.
- R11: Fills, victim choice and pointers of one set leave every other set unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_valid | input | 1 | Read request this cycle |
| rd_addr | input | 32 | Byte address of the read |
| fill_valid | input | 1 | Line fill this cycle |
| fill_set | input | 7 | Set receiving the fill |
| fill_tag | input | 20 | Full tag of the filled line |
| fill_data | input | 256 | Line contents, word 0 in the low bits |
| rsp_valid | output | 1 | Response to the previous cycle's read |
| rsp_hit | output | 1 | Full tag matched; rsp_data is valid |
| rsp_miss | output | 1 | Read missed; a fill is requested |
| rsp_data | output | 32 | Word from the microtag-selected way |

## Verification
Several properties are checked on every cycle:
- The microtag match vector for the addressed set is never more than one-hot.
- A full-tag match always lies on the microtag-selected way.
- Every read produces exactly one response one cycle later.
- The hit flag follows the full-tag compare.
- The data is zero when no microtag matches.

Other behaviours appear only across sequences of operations in the bench's scenarios:
- which way a fill evicts under each of the three victim rules;
- the round-robin order and its independence per set;
- the aliased data returned when only the microtag matches;
- read-before-fill ordering within one cycle.

// File: rtl/utc_pkg.sv
package utc_pkg;
    localparam int WORD_W = 32;
    localparam int BYTE_W = 8;
    typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/utc_match.sv
// Per-way compare of one set: short microtag compare for way select and a
// full tag compare for the hit decision, both from the same row.
module utc_match #(
    parameter int WAYS   = 4,
    parameter int TAG_W  = 20,
    parameter int UTAG_W = 8
) (
    input  logic [WAYS-1:0]             row_vld,
    input  logic [WAYS-1:0][TAG_W-1:0]  row_tags,
    input  logic [WAYS-1:0][UTAG_W-1:0] row_utags,
    input  logic [TAG_W-1:0]            req_tag,
    output logic [WAYS-1:0]             utag_oh,
    output logic [WAYS-1:0]             tag_oh
);
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign utag_oh[w] = row_vld[w] && (row_utags[w] == req_tag[UTAG_W-1:0]);
        assign tag_oh[w]  = row_vld[w] && (row_tags[w] == req_tag);
    end
endmodule

// File: rtl/utc_wordsel.sv
// AND-OR way mux driven by a one-hot select, word picked inside each line.
module utc_wordsel
    import utc_pkg::*;
#(
    parameter int WAYS   = 4,
    parameter int WORDS  = 8,
    parameter int WSEL_W = 3,
    parameter int LINE_W = WORDS * WORD_W
) (
    input  logic [WAYS-1:0][LINE_W-1:0] lines,
    input  logic [WAYS-1:0]             sel_oh,
    input  logic [WSEL_W-1:0]           word_idx,
    output word_t                       word
);
    always_comb begin
        word = '0;
        for (int w = 0; w < WAYS; w++) begin
            word = word | ({WORD_W{sel_oh[w]}} & lines[w][WORD_W*word_idx +: WORD_W]);
        end
    end
endmodule

// File: rtl/utc_victim.sv
// Fill way choice: same-microtag way first, then lowest invalid way, then
// the set's round-robin pointer.
module utc_victim #(
    parameter int WAYS   = 4,
    parameter int UTAG_W = 8,
    parameter int WAY_W  = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]             row_vld,
    input  logic [WAYS-1:0][UTAG_W-1:0] row_utags,
    input  logic [UTAG_W-1:0]           new_utag,
    input  logic [WAY_W-1:0]            rr_ptr,
    output logic [WAY_W-1:0]            way,
    output logic                        use_rr
);
    logic             same_hit, free_hit;
    logic [WAY_W-1:0] same_way, free_way;

    always_comb begin
        same_hit = 1'b0;
        same_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (row_vld[w] && (row_utags[w] == new_utag)) begin
                same_hit = 1'b1;
                same_way = WAY_W'(w);
            end
        end
        free_hit = 1'b0;
        free_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!row_vld[w]) begin
                free_hit = 1'b1;
                free_way = WAY_W'(w);
            end
        end
        if (same_hit) begin
            way    = same_way;
            use_rr = 1'b0;
        end else if (free_hit) begin
            way    = free_way;
            use_rr = 1'b0;
        end else begin
            way    = rr_ptr;
            use_rr = 1'b1;
        end
    end
endmodule

// File: rtl/utc_cache.sv
module utc_cache
    import utc_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int SETS       = 128,
    parameter int WAYS       = 4,
    parameter int LINE_BYTES = 32,
    parameter int UTAG_W     = 8,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int IDX_W     = $clog2(SETS),
    localparam int TAG_W     = ADDR_W - IDX_W - OFF_W,
    localparam int LINE_W    = LINE_BYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_valid,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              fill_valid,
    input  logic [IDX_W-1:0]  fill_set,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [LINE_W-1:0] fill_data,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_miss,
    output word_t             rsp_data
);
    localparam int WORD_BYTES = WORD_W / BYTE_W;
    localparam int WORDS      = LINE_BYTES / WORD_BYTES;
    localparam int BSEL_W     = $clog2(WORD_BYTES);
    localparam int WSEL_W     = OFF_W - BSEL_W;
    localparam int WAY_W      = $clog2(WAYS);

    typedef struct packed {
        logic [SETS-1:0][WAYS-1:0]  vld;
        logic [SETS-1:0][WAY_W-1:0] rr;
        logic                       rsp_valid;
        logic                       rsp_hit;
        word_t                      rsp_data;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    // Address fields of the read
    logic [WSEL_W-1:0] rd_word;
    logic [IDX_W-1:0]  rd_set;
    logic [TAG_W-1:0]  rd_tag;
    logic              unused_byte_bits;

    assign rd_word          = rd_addr[OFF_W-1:BSEL_W];
    assign rd_set           = rd_addr[OFF_W+IDX_W-1:OFF_W];
    assign rd_tag           = rd_addr[ADDR_W-1:OFF_W+IDX_W];
    assign unused_byte_bits = ^rd_addr[BSEL_W-1:0];

    // Storage: full tags, microtags and line data in separate arrays
    logic [TAG_W-1:0]  tag_mem  [SETS][WAYS];
    logic [UTAG_W-1:0] utag_mem [SETS][WAYS];
    logic [LINE_W-1:0] data_mem [SETS][WAYS];

    logic [WAYS-1:0][TAG_W-1:0]  rd_tags;
    logic [WAYS-1:0][UTAG_W-1:0] rd_utags;
    logic [WAYS-1:0][LINE_W-1:0] rd_lines;
    logic [WAYS-1:0][UTAG_W-1:0] fl_utags;
    logic [WAYS-1:0]             rd_vld_row, fl_vld_row;

    for (genvar w = 0; w < WAYS; w++) begin : g_rows
        assign rd_tags[w]  = tag_mem[rd_set][w];
        assign rd_utags[w] = utag_mem[rd_set][w];
        assign rd_lines[w] = data_mem[rd_set][w];
        assign fl_utags[w] = utag_mem[fill_set][w];
    end

    assign rd_vld_row = ctl_q.vld[rd_set];
    assign fl_vld_row = ctl_q.vld[fill_set];

    logic [WAYS-1:0] rd_utag_oh, rd_tag_oh;
    word_t           sel_word;
    logic [WAY_W-1:0] vict_way;
    logic            vict_rr;
    logic [UTAG_W-1:0] fill_utag;

    assign fill_utag = fill_tag[UTAG_W-1:0];

    utc_match #(
        .WAYS   (WAYS),
        .TAG_W  (TAG_W),
        .UTAG_W (UTAG_W)
    ) u_match (
        .row_vld   (rd_vld_row),
        .row_tags  (rd_tags),
        .row_utags (rd_utags),
        .req_tag   (rd_tag),
        .utag_oh   (rd_utag_oh),
        .tag_oh    (rd_tag_oh)
    );

    utc_wordsel #(
        .WAYS   (WAYS),
        .WORDS  (WORDS),
        .WSEL_W (WSEL_W),
        .LINE_W (LINE_W)
    ) u_wsel (
        .lines    (rd_lines),
        .sel_oh   (rd_utag_oh),
        .word_idx (rd_word),
        .word     (sel_word)
    );

    utc_victim #(
        .WAYS   (WAYS),
        .UTAG_W (UTAG_W),
        .WAY_W  (WAY_W)
    ) u_vict (
        .row_vld   (fl_vld_row),
        .row_utags (fl_utags),
        .new_utag  (fill_utag),
        .rr_ptr    (ctl_q.rr[fill_set]),
        .way       (vict_way),
        .use_rr    (vict_rr)
    );

    always_comb begin
        ctl_d           = ctl_q;
        ctl_d.rsp_valid = rd_valid;
        ctl_d.rsp_hit   = rd_valid && (|rd_tag_oh);
        ctl_d.rsp_data  = rd_valid ? sel_word : '0;
        if (fill_valid) begin
            ctl_d.vld[fill_set][vict_way] = 1'b1;
            if (vict_rr) begin
                ctl_d.rr[fill_set] = ctl_q.rr[fill_set] + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_valid) begin
            tag_mem[fill_set][vict_way]  <= fill_tag;
            utag_mem[fill_set][vict_way] <= fill_utag;
            data_mem[fill_set][vict_way] <= fill_data;
        end
    end

    assign rsp_valid = ctl_q.rsp_valid;
    assign rsp_hit   = ctl_q.rsp_hit;
    assign rsp_miss  = ctl_q.rsp_valid && !ctl_q.rsp_hit;
    assign rsp_data  = ctl_q.rsp_data;
endmodule

// File: rtl/utc_cache_chk.sv
module utc_cache_chk #(
    parameter int WAYS   = 4,
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_valid,
    input logic [WAYS-1:0]   rd_utag_oh,
    input logic [WAYS-1:0]   rd_tag_oh,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic [WORD_W-1:0] rsp_data
);
    assert_resp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> rsp_valid);

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |=> (!rsp_valid && !rsp_hit && rsp_data == '0));

    assert_hit_from_tag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> (rsp_hit == $past(|rd_tag_oh)));

    assert_tag_on_utag_way_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_tag_oh & ~rd_utag_oh) == '0);

    assert_no_utag_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_utag_oh == '0) |=> (rsp_data == '0));

    assert_unique_utag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rd_utag_oh));
endmodule

bind utc_cache utc_cache_chk #(
    .WAYS   (WAYS),
    .WORD_W (32)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_valid   (rd_valid),
    .rd_utag_oh (rd_utag_oh),
    .rd_tag_oh  (rd_tag_oh),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit),
    .rsp_data   (rsp_data)
);

// File: tb/sim_utc_cache.sv
`timescale 1ns/1ps
module sim_utc_cache;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         rd_valid = 1'b0;
    logic [31:0]  rd_addr = '0;
    logic         fill_valid = 1'b0;
    logic [6:0]   fill_set = '0;
    logic [19:0]  fill_tag = '0;
    logic [255:0] fill_data = '0;
    logic         rsp_valid, rsp_hit, rsp_miss;
    logic [31:0]  rsp_data;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;

    always #2 clk = ~clk;

    utc_cache u0 (
        .clk(clk), .rst_n(rst_n),
        .rd_valid(rd_valid), .rd_addr(rd_addr),
        .fill_valid(fill_valid), .fill_set(fill_set),
        .fill_tag(fill_tag), .fill_data(fill_data),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_miss(rsp_miss), .rsp_data(rsp_data)
    );

    // Reference model
    bit         m_vld  [128][4];
    bit [19:0]  m_tag  [128][4];
    bit [255:0] m_data [128][4];
    int         m_rr   [128];

    function automatic bit [255:0] mk_line(int s);
        bit [255:0] l;
        for (int i = 0; i < 8; i++) l[i*32 +: 32] = 32'hA000_0000 + s * 256 + i;
        return l;
    endfunction

    function automatic bit [31:0] mk_addr(bit [19:0] t, bit [6:0] s, bit [2:0] wd);
        return {t, s, wd, 2'b00};
    endfunction

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic step(bit rv, bit [31:0] ra, bit fv, bit [6:0] fs, bit [19:0] ft,
                        bit [255:0] fd, string req);
        bit        e_hit;
        bit [31:0] e_data;
        int        v;
        bit [6:0]  st;
        bit [19:0] tg;
        bit [2:0]  wi;
        @(negedge clk);
        rd_valid = rv; rd_addr = ra;
        fill_valid = fv; fill_set = fs; fill_tag = ft; fill_data = fd;
        st = ra[11:5]; tg = ra[31:12]; wi = ra[4:2];
        e_hit = 1'b0; e_data = '0;
        if (rv) begin
            for (int w = 0; w < 4; w++) begin
                if (m_vld[st][w] && m_tag[st][w][7:0] == tg[7:0]) e_data = m_data[st][w][wi*32 +: 32];
                if (m_vld[st][w] && m_tag[st][w] == tg) e_hit = 1'b1;
            end
        end
        if (fv) begin
            v = -1;
            for (int w = 0; w < 4; w++) if (m_vld[fs][w] && m_tag[fs][w][7:0] == ft[7:0]) v = w;
            if (v < 0) for (int w = 3; w >= 0; w--) if (!m_vld[fs][w]) v = w;
            if (v < 0) begin v = m_rr[fs]; m_rr[fs] = (m_rr[fs] + 1) % 4; end
            m_vld[fs][v] = 1'b1; m_tag[fs][v] = ft; m_data[fs][v] = fd;
        end
        @(posedge clk);
        #1;
        chk(rsp_valid == rv, req, "rsp_valid", 32'(rsp_valid), 32'(rv));
        chk(rsp_hit == e_hit, req, "rsp_hit", 32'(rsp_hit), 32'(e_hit));
        chk(rsp_miss == (rv && !e_hit), req, "rsp_miss", 32'(rsp_miss), 32'(rv && !e_hit));
        chk(rsp_data == e_data, req, "rsp_data", rsp_data, e_data);
    endtask

    task automatic rd(bit [31:0] a, string req);
        step(1'b1, a, 1'b0, '0, '0, '0, req);
    endtask

    task automatic fl(bit [6:0] s, bit [19:0] t, int seed, string req);
        step(1'b0, '0, 1'b1, s, t, mk_line(seed), req);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual hung expected finished");
            finish_run();
        end
    end

    localparam bit [6:0]  S1 = 7'd3;
    localparam bit [6:0]  S2 = 7'd4;
    localparam bit [19:0] TA = 20'h12345;
    localparam bit [19:0] TB = 20'h22346;
    localparam bit [19:0] TC = 20'h54345;
    localparam bit [19:0] TD = 20'h00099;
    localparam bit [19:0] TE = 20'h000AA;
    localparam bit [19:0] TF = 20'h000BB;
    localparam bit [19:0] TG = 20'h000CC;

    initial begin
        for (int s = 0; s < 128; s++) begin
            m_rr[s] = 0;
            for (int w = 0; w < 4; w++) m_vld[s][w] = 1'b0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk(rsp_valid == 1'b0, "R1", "reset rsp_valid", 32'(rsp_valid), 0);
        chk(rsp_hit == 1'b0, "R1", "reset rsp_hit", 32'(rsp_hit), 0);
        chk(rsp_miss == 1'b0, "R1", "reset rsp_miss", 32'(rsp_miss), 0);
        chk(rsp_data == '0, "R1", "reset rsp_data", rsp_data, 0);
        rd(mk_addr(TA, S1, 3'd0), "R1");
        // R8 fill into empty set, R3 word selection
        fl(S1, TA, 1, "R8");
        for (int i = 0; i < 8; i++) rd(mk_addr(TA, S1, 3'(i)) | 32'(i % 4), "R3");
        // R10 read and fill same cycle
        step(1'b1, mk_addr(TB, S1, 3'd2), 1'b1, S1, TB, mk_line(2), "R10");
        rd(mk_addr(TB, S1, 3'd2), "R10");
        rd(mk_addr(TA, S1, 3'd7), "R8");
        // R5 microtag alias, R6 no microtag match
        rd(mk_addr(TC, S1, 3'd5), "R5");
        rd(mk_addr(TD, S1, 3'd1), "R6");
        // R7 same-microtag fill replaces
        fl(S1, TC, 3, "R7");
        rd(mk_addr(TA, S1, 3'd4), "R7");
        rd(mk_addr(TC, S1, 3'd4), "R7");
        rd(mk_addr(TB, S1, 3'd0), "R7");
        // R9 round robin in a full set
        fl(S1, TD, 4, "R8");
        fl(S1, TE, 5, "R8");
        fl(S1, TF, 6, "R9");
        rd(mk_addr(TC, S1, 3'd1), "R9");
        rd(mk_addr(TF, S1, 3'd1), "R9");
        fl(S1, TG, 7, "R9");
        rd(mk_addr(TB, S1, 3'd6), "R9");
        rd(mk_addr(TD, S1, 3'd6), "R9");
        rd(mk_addr(TG, S1, 3'd6), "R9");
        // R11 other set independent
        fl(S2, TA, 8, "R11");
        rd(mk_addr(TA, S2, 3'd2), "R11");
        rd(mk_addr(TA, S1, 3'd2), "R11");
        rd(mk_addr(TE, S1, 3'd2), "R11");
        // R2 idle cycle
        step(1'b0, mk_addr(TE, S1, 3'd2), 1'b0, '0, '0, '0, "R2");
        // Random mix with colliding microtags
        for (int n = 0; n < 4000; n++) begin
            bit [6:0]  rs, fs;
            bit [19:0] rt, ft;
            int        sp;
            sp = $urandom % 4; rs = (sp == 3) ? 7'd127 : 7'(sp);
            sp = $urandom % 4; fs = (sp == 3) ? 7'd127 : 7'(sp);
            rt = {12'($urandom % 4), 8'(8'h40 + $urandom % 3)};
            ft = {12'($urandom % 4), 8'(8'h40 + $urandom % 3)};
            step(($urandom % 2) == 0, mk_addr(rt, rs, 3'($urandom % 8)),
                 ($urandom % 10) < 3, fs, ft, mk_line(100 + n), "R4 R5 R7 R9");
        end
        finish_run();
    end
endmodule